// File: doc/BRIEF.md
# Sequential Stream Data Prefetcher

This block watches the line misses of the level-one data cache and looks for runs of misses that walk through memory one 128-byte line at a time, either upward or downward. Once such a run is confirmed it sends line addresses for the lines that come next in the run to the level-two request port, so that those lines are on their way before the loads ask for them. A table of a fixed number of stream entries lets several independent runs be followed at the same time.

Each entry records the last line the loads asked for, the direction of the run, whether the run has been confirmed, the target distance ahead, and how many lines beyond the last demand line have already been requested. The target distance starts small and grows as the run keeps advancing. Software can force a distance by sending a touch hint with a miss. A run is abandoned when its next line would leave the 4 KB page of its last demand line. Requests leave one per cycle through a valid/ready pair, with the entries taking turns.

Top module: `pf_stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low, and it stays low until some stream has been confirmed; a single miss never produces a request.
- R2: A miss confirms an unconfirmed entry only when its line is exactly one above or one below that entry's line. A miss on the same line only refreshes the entry's recency, and a miss two or more lines away allocates a separate entry.
- R3: On confirmation of an ascending run the block requests the two following lines, in order, as byte addresses that are line-aligned and step by 128.
- R4: Each further miss on the next line of a confirmed run advances it and raises the target distance 2, 4, 8, 12, then stays at 12; requests never run more than 12 lines beyond the latest demand line.
- R5: A run confirmed by a miss one line below the previous one is descending, and its requests step down by 128 bytes.
- R6: A miss carrying `hint_valid` that confirms or advances a run sets its target distance to `hint_depth` (a 4-bit count, values above 12 taken as 12); after that the distance no longer ramps by itself, and a later hint replaces it.
- R7: A run whose next request line lies in a different 4 KB page from its latest demand line is dropped: that line is not requested, and a later miss on what would have been the run's next line does not produce requests.
- R8: At most one request is accepted per cycle, on a cycle with `pf_valid` and `pf_ready` both high; while `pf_ready` is low and no miss arrives, `pf_valid` stays high and `pf_addr` stays unchanged.
- R9: A new run takes the lowest-numbered free entry, and entries with requests pending are served in turn, starting from the entry after the one served last (entry 0 first after reset).
- R10: When all entries are in use, a miss that matches none of them replaces the least recently touched entry; a miss on an entry's own line counts as a touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | A data-cache line miss is presented this cycle |
| miss_addr | input | ADDR_W | Byte address of the missing load |
| hint_valid | input | 1 | The miss carries a software depth hint |
| hint_depth | input | HINT_W | Requested distance ahead in lines (clamped to 12) |
| pf_ready | input | 1 | The level-two request port accepts a request this cycle |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Line-aligned byte address of the offered request |

## Verification
A wrong entry field shows at the ports on the very next request: a bad direction or demand line gives a wrong address in the first request after confirmation, and a bad issued count or distance gives one line too many or too few in the burst that follows each advancing miss, so the scoreboard sees it within a few cycles. Recency and turn-taking faults only become visible later, as a wrong stream surviving a replacement or as requests of two streams arriving in the wrong interleaving, so the bench provokes both with fixed entry placements. A missed page drop shows as an extra request across the page edge, which the scoreboard reports as unexpected.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_RUN   = 2'd2
  } pf_state_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } pf_dir_e;

endpackage

// File: rtl/pf_lru_rank.sv
module pf_lru_rank #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);

  // rank 0 is most recent, rank N-1 is least recent
  logic [IDX_W-1:0] rank_q [N];
  logic [IDX_W-1:0] rank_d [N];

  always_comb begin
    rank_d = rank_q;
    if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)
          rank_d[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx])
          rank_d[i] = rank_q[i] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++)
      if (rank_q[i] == IDX_W'(N-1)) lru_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch) begin
      rank_q <= rank_d;
    end
  end

endmodule

// File: rtl/pf_rr_pick.sv
module pf_rr_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             accept,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = N-1; k >= 0; k--) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (req[j]) begin
        gnt_any = 1'b1;
        gnt_idx = IDX_W'(j);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (accept && gnt_any)
      ptr_d = (gnt_idx == IDX_W'(N-1)) ? '0 : gnt_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (accept && gnt_any) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/pf_stream_prefetcher.sv
module pf_stream_prefetcher
  import pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int PAGE_BYTES = 4096,
  parameter int NSTREAM    = 8,
  parameter int MAX_DEPTH  = 12,
  parameter int INIT_DEPTH = 2,
  parameter int HINT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              hint_valid,
  input  logic [HINT_W-1:0] hint_depth,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int LINE_W  = ADDR_W - LINE_SH;
  localparam int PG_SH   = $clog2(PAGE_BYTES) - LINE_SH;
  localparam int IDX_W   = $clog2(NSTREAM);
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // stream table
  pf_state_e         st_q   [NSTREAM];
  pf_state_e         st_d   [NSTREAM];
  pf_dir_e           dir_q  [NSTREAM];
  pf_dir_e           dir_d  [NSTREAM];
  logic [LINE_W-1:0] last_q [NSTREAM];
  logic [LINE_W-1:0] last_d [NSTREAM];
  logic [DEPTH_W-1:0] iss_q [NSTREAM];
  logic [DEPTH_W-1:0] iss_d [NSTREAM];
  logic [DEPTH_W-1:0] dep_q [NSTREAM];
  logic [DEPTH_W-1:0] dep_d [NSTREAM];
  logic              hnt_q  [NSTREAM];
  logic              hnt_d  [NSTREAM];

  logic [LINE_W-1:0] miss_line;
  logic [LINE_W-1:0] next_line [NSTREAM];
  logic [NSTREAM-1:0] hit_same, hit_up, hit_dn, hit, req, drop;

  assign miss_line = miss_addr[ADDR_W-1:LINE_SH];

  for (genvar i = 0; i < NSTREAM; i++) begin : g_ent
    logic              busy, want;
    logic [LINE_W-1:0] ahead;
    assign busy  = (st_q[i] != ST_IDLE);
    assign ahead = LINE_W'(iss_q[i]) + LINE_W'(1);
    assign next_line[i] = (dir_q[i] == DIR_UP) ? last_q[i] + ahead : last_q[i] - ahead;
    assign hit_same[i] = busy && (miss_line == last_q[i]);
    assign hit_up[i]   = busy && (miss_line == last_q[i] + LINE_W'(1)) &&
                         (st_q[i] == ST_TRAIN || dir_q[i] == DIR_UP);
    assign hit_dn[i]   = busy && (miss_line == last_q[i] - LINE_W'(1)) &&
                         (st_q[i] == ST_TRAIN || dir_q[i] == DIR_DOWN);
    assign hit[i]  = hit_same[i] | hit_up[i] | hit_dn[i];
    assign want    = (st_q[i] == ST_RUN) && (iss_q[i] < dep_q[i]);
    assign drop[i] = want && (next_line[i][LINE_W-1:PG_SH] != last_q[i][LINE_W-1:PG_SH]);
    assign req[i]  = want && !drop[i];
  end

  // target entry of the current miss
  logic             any_hit, any_idle;
  logic [IDX_W-1:0] hit_idx, idle_idx, lru_idx, tgt_idx;

  always_comb begin
    any_hit  = 1'b0;
    any_idle = 1'b0;
    hit_idx  = '0;
    idle_idx = '0;
    for (int i = NSTREAM-1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (st_q[i] == ST_IDLE) begin
        any_idle = 1'b1;
        idle_idx = IDX_W'(i);
      end
    end
    tgt_idx = any_hit ? hit_idx : (any_idle ? idle_idx : lru_idx);
  end

  pf_lru_rank #(.N(NSTREAM), .IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_ni),
    .touch    (miss_valid),
    .touch_idx(tgt_idx),
    .lru_idx  (lru_idx)
  );

  logic             gnt_any, take;
  logic [IDX_W-1:0] gnt_idx;

  pf_rr_pick #(.N(NSTREAM), .IDX_W(IDX_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_ni),
    .req    (req),
    .accept (pf_ready),
    .gnt_any(gnt_any),
    .gnt_idx(gnt_idx)
  );

  assign pf_valid = gnt_any;
  assign pf_addr  = {next_line[gnt_idx], {LINE_SH{1'b0}}};
  assign take     = pf_valid && pf_ready;

  // depth helpers
  logic [DEPTH_W-1:0] hint_clamped;
  assign hint_clamped = (hint_depth > HINT_W'(MAX_DEPTH)) ? DEPTH_W'(MAX_DEPTH)
                                                           : DEPTH_W'(hint_depth);

  function automatic logic [DEPTH_W-1:0] ramp(input logic [DEPTH_W-1:0] d);
    logic [DEPTH_W:0] dbl;
    dbl = {d, 1'b0};
    return (dbl > (DEPTH_W+1)'(MAX_DEPTH)) ? DEPTH_W'(MAX_DEPTH) : dbl[DEPTH_W-1:0];
  endfunction

  // next state
  always_comb begin
    st_d   = st_q;
    dir_d  = dir_q;
    last_d = last_q;
    iss_d  = iss_q;
    dep_d  = dep_q;
    hnt_d  = hnt_q;
    for (int i = 0; i < NSTREAM; i++) begin
      logic g;
      g = take && (gnt_idx == IDX_W'(i));
      if (g)       iss_d[i] = iss_q[i] + DEPTH_W'(1);
      if (drop[i]) st_d[i]  = ST_IDLE;
      if (miss_valid && (tgt_idx == IDX_W'(i))) begin
        if (!any_hit) begin
          st_d[i]   = ST_TRAIN;
          dir_d[i]  = DIR_UP;
          last_d[i] = miss_line;
          iss_d[i]  = '0;
          dep_d[i]  = DEPTH_W'(INIT_DEPTH);
          hnt_d[i]  = 1'b0;
        end else if (hit_same[i]) begin
          // recency refresh only
        end else if (st_q[i] == ST_TRAIN) begin
          st_d[i]   = ST_RUN;
          dir_d[i]  = hit_up[i] ? DIR_UP : DIR_DOWN;
          last_d[i] = miss_line;
          iss_d[i]  = '0;
          dep_d[i]  = hint_valid ? hint_clamped : DEPTH_W'(INIT_DEPTH);
          hnt_d[i]  = hint_valid;
        end else begin
          st_d[i]   = ST_RUN;
          last_d[i] = miss_line;
          iss_d[i]  = (iss_q[i] == '0 && !g) ? '0 : iss_q[i] + DEPTH_W'(g) - DEPTH_W'(1);
          dep_d[i]  = hint_valid ? hint_clamped : (hnt_q[i] ? dep_q[i] : ramp(dep_q[i]));
          hnt_d[i]  = hnt_q[i] | hint_valid;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTREAM; i++) begin
        st_q[i]   <= ST_IDLE;
        dir_q[i]  <= DIR_UP;
        last_q[i] <= '0;
        iss_q[i]  <= '0;
        dep_q[i]  <= '0;
        hnt_q[i]  <= 1'b0;
      end
    end else begin
      st_q   <= st_d;
      dir_q  <= dir_d;
      last_q <= last_d;
      iss_q  <= iss_d;
      dep_q  <= dep_d;
      hnt_q  <= hnt_d;
    end
  end

endmodule

// File: rtl/pf_stream_prefetcher_chk.sv
module pf_stream_prefetcher_chk #(
  parameter int ADDR_W  = 32,
  parameter int LINE_SH = 7,
  parameter int LINE_W  = 25,
  parameter int PG_SH   = 5,
  parameter int NSTREAM = 8,
  parameter int IDX_W   = 3,
  parameter int DEPTH_W = 4,
  parameter int MAX_DEPTH = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [ADDR_W-1:0]  pf_addr,
  input logic [IDX_W-1:0]   gnt_idx,
  input logic [LINE_W-1:0]  last_q [NSTREAM],
  input logic [DEPTH_W-1:0] iss_q  [NSTREAM],
  input logic [DEPTH_W-1:0] dep_q  [NSTREAM]
);

  logic [1:0] miss_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_cnt <= 2'd0;
    else if (miss_valid && miss_cnt != 2'd2) miss_cnt <= miss_cnt + 2'd1;
  end

  // R1: no request before two misses have been seen
  a_r1_two_misses: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (miss_cnt == 2'd2));

  // R8: offered request held while the port stalls and no miss arrives
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !miss_valid) |=> (pf_valid && $stable(pf_addr)));

  // R7: every request stays inside the page of its stream's demand line
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[ADDR_W-1:LINE_SH+PG_SH] == last_q[gnt_idx][LINE_W-1:PG_SH]));

  // R4: no entry runs more than the maximum distance ahead
  for (genvar i = 0; i < NSTREAM; i++) begin : g_lim
    a_r4_ahead_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_q[i] <= DEPTH_W'(MAX_DEPTH)) && (dep_q[i] <= DEPTH_W'(MAX_DEPTH)));
  end

endmodule

bind pf_stream_prefetcher pf_stream_prefetcher_chk #(
  .ADDR_W(ADDR_W), .LINE_SH(LINE_SH), .LINE_W(LINE_W), .PG_SH(PG_SH),
  .NSTREAM(NSTREAM), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W), .MAX_DEPTH(MAX_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_ni), .miss_valid(miss_valid), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr), .gnt_idx(gnt_idx),
  .last_q(last_q), .iss_q(iss_q), .dep_q(dep_q)
);

// File: tb/tb_pf_stream_prefetcher.sv
module tb_pf_stream_prefetcher;

  logic        clk;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic        hint_valid;
  logic [3:0]  hint_depth;
  logic        pf_ready;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  pf_stream_prefetcher dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .hint_valid(hint_valid), .hint_depth(hint_depth), .pf_ready(pf_ready),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compare each accepted request against the scoreboard
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected request: actual %h expected none", pf_addr);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (pf_addr !== e) begin
          errors++;
          $display("FAIL %s request: actual %h expected %h", t, pf_addr, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_line(input logic [24:0] line, input string tag);
    exp_q.push_back({line, 7'b0});
    tag_q.push_back(tag);
  endtask

  task automatic miss(input logic [24:0] line, input bit hv, input logic [3:0] hd);
    @(posedge clk); #2;
    miss_valid = 1'b1;
    miss_addr  = {line, 7'h15};
    hint_valid = hv;
    hint_depth = hd;
    @(posedge clk); #2;
    miss_valid = 1'b0;
    hint_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drained(input string tag);
    settle(20);
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic set_ready(input bit r);
    @(posedge clk); #2;
    pf_ready = r;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    settle(3);
    #2 rst_n = 1'b1;
    settle(4);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(pf_valid == 1'b0, tag, {31'b0, pf_valid}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0;
    hint_valid = 1'b0; hint_depth = '0; pf_ready = 1'b1;
    settle(3);
    #2 rst_n = 1'b1;
    settle(4);

    // R1: quiet after reset and after a lone miss
    idle_check("R1 reset");
    miss(25'h100, 0, 0); settle(10);
    idle_check("R1 single miss");
    miss(25'h100, 0, 0); settle(10);
    idle_check("R2 same line");

    // R8: stall then release; R3 first burst
    set_ready(0);
    miss(25'h101, 0, 0); settle(3);
    @(negedge clk);
    chk(pf_valid && pf_addr == 32'h8100, "R8 offered while stalled", pf_addr, 32'h8100);
    settle(2);
    @(negedge clk);
    chk(pf_valid && pf_addr == 32'h8100, "R8 held stable", pf_addr, 32'h8100);
    expect_line(25'h102, "R3"); expect_line(25'h103, "R3");
    set_ready(1);
    drained("R3 ascending burst");

    // R4: ramp 4, 8, 12 and capped distance
    expect_line(25'h104, "R4"); expect_line(25'h105, "R4"); expect_line(25'h106, "R4");
    miss(25'h102, 0, 0); drained("R4 depth 4");
    for (int l = 'h107; l <= 'h10B; l++) expect_line(25'(l), "R4");
    miss(25'h103, 0, 0); drained("R4 depth 8");
    for (int l = 'h10C; l <= 'h110; l++) expect_line(25'(l), "R4");
    miss(25'h104, 0, 0); drained("R4 depth 12");
    expect_line(25'h111, "R4");
    miss(25'h105, 0, 0); drained("R4 capped");
    expect_line(25'h112, "R4");
    miss(25'h106, 0, 0); drained("R4 capped again");

    // R5 descending, R7 page drop
    do_reset();
    miss(25'h45, 0, 0);
    expect_line(25'h43, "R5"); expect_line(25'h42, "R5");
    miss(25'h44, 0, 0); drained("R5 descending burst");
    expect_line(25'h41, "R7"); expect_line(25'h40, "R7");
    miss(25'h43, 0, 0); drained("R7 stop at page start");
    miss(25'h42, 0, 0); settle(10);
    idle_check("R7 stream dropped");

    // R6 hints
    do_reset();
    miss(25'h300, 0, 0);
    for (int l = 'h302; l <= 'h307; l++) expect_line(25'(l), "R6");
    miss(25'h301, 1, 4'd6); drained("R6 hinted depth 6");
    expect_line(25'h308, "R6");
    miss(25'h302, 0, 0); drained("R6 no ramp after hint");
    for (int l = 'h309; l <= 'h30F; l++) expect_line(25'(l), "R6");
    miss(25'h303, 1, 4'd15); drained("R6 hint clamped to 12");
    expect_line(25'h310, "R6");
    miss(25'h304, 0, 0); drained("R6 clamped depth kept");

    // R9 allocation order and turn taking
    do_reset();
    set_ready(0);
    miss(25'h500, 0, 0); miss(25'h600, 0, 0);
    miss(25'h501, 0, 0); miss(25'h601, 0, 0);
    settle(2);
    expect_line(25'h502, "R9"); expect_line(25'h602, "R9");
    expect_line(25'h503, "R9"); expect_line(25'h603, "R9");
    set_ready(1);
    drained("R9 round robin");

    // R2 distance two does not confirm
    do_reset();
    miss(25'h700, 0, 0); miss(25'h702, 0, 0); settle(10);
    idle_check("R2 gap of two");
    expect_line(25'h704, "R2"); expect_line(25'h705, "R2");
    miss(25'h703, 0, 0); drained("R2 confirm from newer entry");

    // R10 replacement of least recently touched entry
    do_reset();
    for (int i = 0; i < 8; i++) miss(25'h1000 + 25'(i * 'h40), 0, 0);
    miss(25'h1000, 0, 0);
    miss(25'h2000, 0, 0);
    miss(25'h1041, 0, 0); settle(10);
    idle_check("R10 entry one evicted");
    miss(25'h1081, 0, 0); settle(10);
    idle_check("R10 entry two evicted");
    expect_line(25'h1002, "R10"); expect_line(25'h1003, "R10");
    miss(25'h1001, 0, 0); drained("R10 refreshed entry kept");
    expect_line(25'h2002, "R10"); expect_line(25'h2003, "R10");
    miss(25'h2001, 0, 0); drained("R10 new entry live");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule